// File: doc/BRIEF.md
# Privileged Segment Address Decoder

This block sorts a 32-bit virtual address into one of five fixed regions and applies the current privilege mode to it. It settles each access one of three ways. In a direct window the physical address is formed right away. In a translated region a lookup request goes to an external translation buffer. In a region the current mode may not touch, the access becomes an address error.

The translation buffer sits outside this block and returns a two-bit result with a physical address. The decoder turns that result into an exception kind. The whole decode is combinational. When a faulting access is presented, three fault-context registers load on the next rising clock edge:

- the faulting address;
- a page-table context word;
- an entry-high word.

An error-level input overrides the low region so that it maps one-to-one. Recovery code can then run without a translation buffer.

Top module: `seg_addr_decoder`

## Requirements
- R1: For an address below 0x80000000 with `err_lvl` high, `pa` equals `vaddr`, `tlb_req` is low and `exc_kind` is 0, in every mode.
- R2: For an address below 0x80000000 with `err_lvl` low, a valid access raises `tlb_req` in every mode.
- R3: For an address from 0x80000000 to 0x9FFFFFFF in kernel mode (`mode` 00), `pa` is `vaddr` minus 0x80000000 and no lookup is requested.
- R4: For an address from 0xA0000000 to 0xBFFFFFFF in kernel mode, `pa` is `vaddr` minus 0xA0000000 and no lookup is requested.
- R5: The region from 0xC0000000 to 0xDFFFFFFF requests a lookup in kernel or supervisor mode (`mode` 01). It is an address error in user mode.
- R6: Addresses from 0xE0000000 upward request a lookup in kernel mode only. Any other mode gives an address error.
- R7: An address error gives `exc_kind` 1 on a load and 2 on a store. The mode code 11 behaves exactly like user mode (10). `err_lvl` does not relax the checks on addresses of 0x80000000 and above.
- R8: A lookup result of no-match (`tlb_res` 01) gives `exc_kind` 3 on a load or 4 on a store, with `refill` high. A result of invalid (`tlb_res` 10) gives the same kinds with `refill` low.
- R9: A lookup result of dirty fault (`tlb_res` 11) gives `exc_kind` 5.
- R10: On a hit (`tlb_res` 00), `pa` equals `tlb_pa` and `exc_kind` is 0. When any exception kind is nonzero, `pa` is 0.
- R11: On a clock edge with `fault` high, the registers load as follows:
  - `badaddr_q` takes `vaddr`.
  - `context_q` bits 22:4 take `vaddr[31:13]`, and its other bits keep their values.
  - `entryhi_q` becomes {`vaddr[31:13]`, 5'b0, `asid`}.
- R12: Reset clears all three registers. They hold their values on every edge without `fault`. With `acc_vld` low, `tlb_req`, `refill`, `fault` and `exc_kind` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_vld | input | 1 | An access is presented this cycle |
| vaddr | input | 32 | Virtual address |
| is_store | input | 1 | 1 for a write, 0 for a read |
| mode | input | 2 | 00 kernel, 01 supervisor, 10 or 11 user |
| err_lvl | input | 1 | Error-level override flag |
| asid | input | 8 | Current address-space identifier |
| tlb_res | input | 2 | 00 hit, 01 no-match, 10 invalid, 11 dirty fault |
| tlb_pa | input | 32 | Physical address returned by the lookup |
| pa | output | 32 | Physical address, 0 on any fault |
| tlb_req | output | 1 | Lookup request for a translated region |
| exc_kind | output | 3 | 0 none, 1 load addr error, 2 store addr error, 3 lookup load, 4 lookup store, 5 modify |
| refill | output | 1 | Fault came from a lookup no-match |
| fault | output | 1 | Valid access with nonzero exception kind |
| badaddr_q | output | 32 | Captured faulting address |
| context_q | output | 32 | Context word with page number in bits 22:4 |
| entryhi_q | output | 32 | Page-pair number and identifier |

## Verification
The bench sweeps every region, mode code, load/store, error-level and lookup-result combination. It uses several low-address patterns, with the access both valid and idle.

Mode code 11 is exercised on purpose. A decoder that read only the low mode bit would treat it as supervisor and let it into the 0xC0000000 region. The error-level flag is applied to the upper regions as well. A design that honoured it there would let user code reach kernel windows.

The bench separates no-match from invalid by the refill flag alone. A merged decode would send invalid entries to the refill path. After every edge the bench checks the captured registers. A decoder that captured on idle cycles, or that shifted the page number by the wrong amount, shows up straight away.

// File: rtl/seg_addr_decoder.sv
module seg_addr_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_vld,
  input  logic [31:0] vaddr,
  input  logic        is_store,
  input  logic [1:0]  mode,
  input  logic        err_lvl,
  input  logic [7:0]  asid,
  input  logic [1:0]  tlb_res,
  input  logic [31:0] tlb_pa,
  output logic [31:0] pa,
  output logic        tlb_req,
  output logic [2:0]  exc_kind,
  output logic        refill,
  output logic        fault,
  output logic [31:0] badaddr_q,
  output logic [31:0] context_q,
  output logic [31:0] entryhi_q
);

  localparam logic [2:0] EK_NONE = 3'd0, EK_ADEL = 3'd1, EK_ADES = 3'd2,
                         EK_TLBL = 3'd3, EK_TLBS = 3'd4, EK_MOD  = 3'd5;
  localparam logic [1:0] TR_HIT = 2'd0, TR_MISS = 2'd1, TR_INV = 2'd2;

  wire is_kern = (mode == 2'b00);
  wire is_sup  = (mode == 2'b01);

  logic        mapped, bad;
  logic [31:0] dpa;
  logic [2:0]  kind;

  always_comb begin
    mapped = 1'b0;
    bad    = 1'b0;
    dpa    = '0;
    if (!vaddr[31]) begin
      if (err_lvl) dpa = vaddr;
      else         mapped = 1'b1;
    end else begin
      case (vaddr[30:29])
        2'b00, 2'b01: if (is_kern) dpa = {3'b000, vaddr[28:0]}; else bad = 1'b1;
        2'b10:        if (is_kern || is_sup) mapped = 1'b1; else bad = 1'b1;
        default:      if (is_kern) mapped = 1'b1; else bad = 1'b1;
      endcase
    end
  end

  always_comb begin
    kind = EK_NONE;
    if (bad)
      kind = is_store ? EK_ADES : EK_ADEL;
    else if (mapped) begin
      case (tlb_res)
        TR_HIT:        kind = EK_NONE;
        TR_MISS, TR_INV: kind = is_store ? EK_TLBS : EK_TLBL;
        default:       kind = EK_MOD;
      endcase
    end
  end

  assign pa       = (kind != EK_NONE) ? '0 : (mapped ? tlb_pa : dpa);
  assign tlb_req  = acc_vld && mapped;
  assign exc_kind = acc_vld ? kind : EK_NONE;
  assign refill   = acc_vld && mapped && (tlb_res == TR_MISS);
  assign fault    = (exc_kind != EK_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badaddr_q <= '0;
      context_q <= '0;
      entryhi_q <= '0;
    end else if (fault) begin
      badaddr_q <= vaddr;
      context_q <= {context_q[31:23], vaddr[31:13], context_q[3:0]};
      entryhi_q <= {vaddr[31:13], 5'b00000, asid};
    end
  end

  // R2 R5 R6
  req_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req |-> (vaddr[31:30] == 2'b11) || (!vaddr[31] && !err_lvl));

  // R7
  user_kseg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && mode[1] && vaddr[31]) |-> (exc_kind == EK_ADEL || exc_kind == EK_ADES));

  // R8
  refill_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill |-> (exc_kind == EK_TLBL || exc_kind == EK_TLBS));

  // R11
  bad_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (badaddr_q == $past(vaddr)) && (entryhi_q[7:0] == $past(asid)));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |=> $stable(badaddr_q) && $stable(context_q) && $stable(entryhi_q));

  // R1
  erl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && err_lvl && !vaddr[31]) |-> (!tlb_req && !fault && pa == vaddr));

endmodule

// File: tb/seg_addr_decoder_tb.sv
module seg_addr_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_vld = 1'b0;
  logic [31:0] vaddr = '0;
  logic        is_store = 1'b0;
  logic [1:0]  mode = '0;
  logic        err_lvl = 1'b0;
  logic [7:0]  asid = '0;
  logic [1:0]  tlb_res = '0;
  logic [31:0] tlb_pa = '0;
  logic [31:0] pa, badaddr_q, context_q, entryhi_q;
  logic        tlb_req, refill, fault;
  logic [2:0]  exc_kind;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  seg_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .vaddr(vaddr),
    .is_store(is_store), .mode(mode), .err_lvl(err_lvl), .asid(asid),
    .tlb_res(tlb_res), .tlb_pa(tlb_pa), .pa(pa), .tlb_req(tlb_req),
    .exc_kind(exc_kind), .refill(refill), .fault(fault),
    .badaddr_q(badaddr_q), .context_q(context_q), .entryhi_q(entryhi_q));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (va=%h mode=%0d st=%0d erl=%0d res=%0d vld=%0d)",
               tag, what, act, exp, vaddr, mode, is_store, err_lvl, tlb_res, acc_vld);
    end
  endtask

  logic [31:0] m_bad, m_ctx, m_eh;

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lows [3];
    lows[0] = 32'h0000_0000;
    lows[1] = 32'h1FFF_FFFF;
    lows[2] = 32'h0A5C_3E71;
    m_bad = '0; m_ctx = '0; m_eh = '0;
    repeat (2) @(negedge clk);
    // R12 reset state
    chk(badaddr_q == 0 && context_q == 0 && entryhi_q == 0, "R12", "reset regs",
        badaddr_q | context_q | entryhi_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int sg = 0; sg < 8; sg++)
    for (int lw = 0; lw < 3; lw++)
    for (int md = 0; md < 4; md++)
    for (int er = 0; er < 2; er++)
    for (int st = 0; st < 2; st++)
    for (int tr = 0; tr < 4; tr++)
    for (int vl = 0; vl < 2; vl++) begin
      logic [31:0] va, e_pa;
      logic        e_req, e_ref, mp, bd;
      logic [2:0]  e_ex;
      string       tag;
      va = {sg[2:0], 29'h0} | lows[lw];
      vaddr = va; mode = md[1:0]; err_lvl = er[0]; is_store = st[0];
      tlb_res = tr[1:0]; acc_vld = vl[0];
      asid = va[7:0] ^ 8'h3C;
      tlb_pa = ~va ^ 32'h1234_5678;
      mp = 0; bd = 0; e_pa = 0; tag = "R1";
      if (sg < 4) begin
        if (er != 0) begin e_pa = va; tag = "R1"; end
        else begin mp = 1; tag = "R2"; end
      end else if (sg == 4) begin
        tag = (md == 0) ? "R3" : "R7";
        if (md == 0) e_pa = va - 32'h8000_0000; else bd = 1;
      end else if (sg == 5) begin
        tag = (md == 0) ? "R4" : "R7";
        if (md == 0) e_pa = va - 32'hA000_0000; else bd = 1;
      end else if (sg == 6) begin
        tag = "R5";
        if (md == 0 || md == 1) mp = 1; else bd = 1;
      end else begin
        tag = "R6";
        if (md == 0) mp = 1; else bd = 1;
      end
      e_ex = 0;
      if (bd) e_ex = st ? 3'd2 : 3'd1;
      else if (mp) begin
        case (tr)
          0: begin e_pa = tlb_pa; tag = "R10"; end
          1, 2: begin e_ex = st ? 3'd4 : 3'd3; tag = "R8"; end
          default: begin e_ex = 3'd5; tag = "R9"; end
        endcase
      end
      if (e_ex != 0) e_pa = 0;
      e_req = vl && mp;
      e_ref = vl && mp && tr == 1;
      if (!vl) begin e_ex = 0; tag = "R12"; end
      #2;
      chk(pa == e_pa, tag, "pa", pa, e_pa);
      chk(tlb_req == e_req, tag, "tlb_req", {31'b0, tlb_req}, {31'b0, e_req});
      chk(exc_kind == e_ex, tag, "exc_kind", {29'b0, exc_kind}, {29'b0, e_ex});
      chk(refill == e_ref, tag, "refill", {31'b0, refill}, {31'b0, e_ref});
      if (e_ex != 0) begin
        m_bad = va;
        m_ctx = (m_ctx & ~32'h007F_FFF0) | ((va >> 9) & 32'h007F_FFF0);
        m_eh  = {va[31:13], 5'b0, va[7:0] ^ 8'h3C};
      end
      @(negedge clk);
      // R11 capture, R12 hold
      chk(badaddr_q == m_bad, (e_ex != 0) ? "R11" : "R12", "badaddr_q", badaddr_q, m_bad);
      chk(context_q == m_ctx, (e_ex != 0) ? "R11" : "R12", "context_q", context_q, m_ctx);
      chk(entryhi_q == m_eh,  (e_ex != 0) ? "R11" : "R12", "entryhi_q", entryhi_q, m_eh);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule